// File: doc/BRIEF.md
# Shared Long-Latency Divide Scheduler

This block arbitrates access to a single core-wide unit that runs non-pipelined operations one at a time: single- and double-precision divide and square root, and integer divide. Eight threads share the unit and are split into two groups of four: threads 0 to 3 form group A and threads 4 to 7 form group B. A thread raises its issue strobe for one cycle with an operation class and, for integer divide, an occupancy value. The request is then held until the unit has executed it.

Service is granted in two levels. Each group keeps its waiting threads in a first-in first-out queue. Between the groups the scheduler alternates whenever both have work. A group with nothing queued leaves the unit to the other group. The arithmetic is not modelled. A down-counter holds the unit busy for the cycle count of the operation. When that count expires, a one-cycle completion strobe goes to the owning thread.

Top module: `lldiv_sched`

## Requirements
- R1: At most one operation occupies the unit at any time. A new operation is granted only while `busy` is low, and every other request waits.
- R2: An operation with class code 2'b00 (single precision) holds `busy` high for exactly 19 consecutive cycles.
- R3: An operation with class code 2'b01 (double precision) holds `busy` high for exactly 33 consecutive cycles.
- R4: An operation whose class code has bit 1 set (integer divide) holds `busy` high for the cycle count taken from its 6-bit latency field. Values below 12 are raised to 12 and values above 41 are lowered to 41. For the other classes the latency field is ignored.
- R5: Within a group, requests are served in the order they arrived. Requests that arrive in the same cycle are served lower thread index first.
- R6: While both groups have queued requests, consecutive grants alternate between the groups, whatever the number of waiters in each.
- R7: When one group has nothing queued, the other group receives every grant in turn.
- R8: A thread has at most one outstanding request. An issue strobe from a thread whose request is still outstanding is ignored: it does not change that request and adds no completion.
- R9: `done[t]` is high for exactly one cycle, in the cycle right after the last busy cycle of thread t's operation, and `busy` is low in that cycle. The next grant starts at the end of that cycle. A thread may issue a new request in its own completion cycle.
- R10: Synchronous reset drives `busy` and `done` low, empties both queues and clears all outstanding requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 8 | Per-thread one-cycle issue strobe |
| req_op | input | 16 | Per-thread operation class, 2 bits per thread (thread t at bits 2t+1:2t) |
| req_lat | input | 48 | Per-thread integer-divide occupancy, 6 bits per thread (thread t at bits 6t+5:6t) |
| done | output | 8 | Per-thread one-cycle completion strobe |
| busy | output | 1 | Unit occupied |

## Verification
One group queue can both pop its head to a grant and append a new arrival on the same clock edge. The bench provokes this by re-issuing from thread 0 in the cycle its completion strobe is high, while thread 2 of the same group is waiting. The grant of thread 2 and the append of thread 0 then fall on the same edge. The result is judged by the completion order 0, 2, 0, by `busy` being low in the completion cycle, and by `busy` rising in the very next cycle.

// File: rtl/lldiv_pkg.sv
package lldiv_pkg;

    localparam int LAT_W = 6;

    typedef enum logic [1:0] {
        OP_SGL     = 2'b00,
        OP_DBL     = 2'b01,
        OP_INT     = 2'b10,
        OP_INT_ALT = 2'b11
    } op_t;

    typedef struct packed {
        op_t              op;
        logic [LAT_W-1:0] ilat;
    } req_rec_t;

    localparam logic [LAT_W-1:0] SGL_CYC = LAT_W'(19);
    localparam logic [LAT_W-1:0] DBL_CYC = LAT_W'(33);
    localparam logic [LAT_W-1:0] INT_MIN = LAT_W'(12);
    localparam logic [LAT_W-1:0] INT_MAX = LAT_W'(41);

    // Occupancy in cycles for one operation; integer values are clamped.
    function automatic logic [LAT_W-1:0] occ_cycles(op_t op, logic [LAT_W-1:0] il);
        logic [LAT_W-1:0] r;
        case (op)
            OP_SGL: r = SGL_CYC;
            OP_DBL: r = DBL_CYC;
            default: begin
                if (il < INT_MIN)      r = INT_MIN;
                else if (il > INT_MAX) r = INT_MAX;
                else                   r = il;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lldiv_grp_queue.sv
module lldiv_grp_queue #(
    parameter int DEPTH = 4,
    localparam int IDW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] push,
    input  logic             pop,
    output logic [IDW-1:0]   head,
    output logic             nonempty
);

    logic [IDW-1:0] q   [DEPTH];
    logic [IDW-1:0] nq  [DEPTH];
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  ncnt;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) nq[i] = q[i];
        ncnt = cnt;
        if (pop && cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) nq[i] = q[i + 1];
            ncnt = cnt - CW'(1);
        end
        // Same-cycle arrivals join in ascending local index.
        for (int t = 0; t < DEPTH; t++) begin
            if (push[t] && ncnt < CW'(DEPTH)) begin
                nq[ncnt[IDW-1:0]] = IDW'(t);
                ncnt = ncnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) q[i] <= '0;
        end else begin
            cnt <= ncnt;
            for (int i = 0; i < DEPTH; i++) q[i] <= nq[i];
        end
    end

    assign head     = q[0];
    assign nonempty = (cnt != '0);

    // R8: one entry per thread, so the queue can never exceed its depth.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R5: a grant only ever pops a queue that holds a waiter.
    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        pop |-> cnt != '0);

endmodule

// File: rtl/lldiv_grp_arb.sv
module lldiv_grp_arb (
    input  logic       clk,
    input  logic       rst,
    input  logic       idle,
    input  logic [1:0] ne,
    output logic       gnt,
    output logic       gsel
);

    logic last;

    assign gnt  = idle && (ne != 2'b00);
    assign gsel = (ne == 2'b11) ? ~last : ne[1];

    always_ff @(posedge clk) begin
        if (rst)      last <= 1'b1;
        else if (gnt) last <= gsel;
    end

    // R6: with both groups loaded the grant goes to the group not served last.
    p_alternate_r6: assert property (@(posedge clk) disable iff (rst)
        (gnt && ne == 2'b11) |=> last != $past(last));

    // R7: a lone loaded group is always the one selected.
    p_yield_r7: assert property (@(posedge clk) disable iff (rst)
        (gnt && ne != 2'b11) |-> ne[gsel]);

endmodule

// File: rtl/lldiv_occ_timer.sv
module lldiv_occ_timer
    import lldiv_pkg::*;
#(
    parameter int NTHR = 8,
    localparam int TIDW = $clog2(NTHR)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [TIDW-1:0]  start_tid,
    input  logic [LAT_W-1:0] start_cyc,
    output logic             busy,
    output logic             finishing,
    output logic [TIDW-1:0]  owner,
    output logic [NTHR-1:0]  done
);

    logic [LAT_W-1:0] cnt;

    assign finishing = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            owner <= '0;
            done  <= '0;
        end else begin
            done <= '0;
            if (start) begin
                busy  <= 1'b1;
                cnt   <= start_cyc - LAT_W'(1);
                owner <= start_tid;
            end else if (finishing) begin
                busy        <= 1'b0;
                done[owner] <= 1'b1;
            end else if (busy) begin
                cnt <= cnt - LAT_W'(1);
            end
        end
    end

    // R1: a start is only ever presented to an idle unit.
    p_start_idle_r1: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R4: the count loaded on a start matches the requested occupancy.
    p_start_load_r4: assert property (@(posedge clk) disable iff (rst)
        start |=> busy && cnt == $past(start_cyc) - LAT_W'(1));

    // R2: the unit stays occupied until its count runs out.
    p_hold_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> busy);

    // R9: a single completion, right after the last busy cycle, with busy low.
    p_done_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done));
    p_done_after_r9: assert property (@(posedge clk) disable iff (rst)
        (done != '0) |-> !busy && $past(busy));

endmodule

// File: rtl/lldiv_sched.sv
module lldiv_sched
    import lldiv_pkg::*;
#(
    parameter int GRP_SZ = 4,
    localparam int N_GRP = 2,
    localparam int NTHR  = N_GRP * GRP_SZ,
    localparam int TIDW  = $clog2(NTHR),
    localparam int LIDW  = $clog2(GRP_SZ)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NTHR-1:0]       req_valid,
    input  logic [2*NTHR-1:0]     req_op,
    input  logic [LAT_W*NTHR-1:0] req_lat,
    output logic [NTHR-1:0]       done,
    output logic                  busy
);

    logic [NTHR-1:0]  pend;
    logic [NTHR-1:0]  acc;
    req_rec_t         rec [NTHR];
    logic [LIDW-1:0]  head [N_GRP];
    logic [N_GRP-1:0] ne;
    logic             gnt;
    logic             gsel;
    logic [TIDW-1:0]  gnt_tid;
    logic [LAT_W-1:0] gnt_cyc;
    logic             finishing;
    logic [TIDW-1:0]  owner;

    assign acc = req_valid & ~pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            for (int t = 0; t < NTHR; t++) rec[t] <= '{op: OP_SGL, ilat: '0};
        end else begin
            for (int t = 0; t < NTHR; t++) begin
                if (acc[t]) begin
                    pend[t] <= 1'b1;
                    rec[t]  <= '{op: op_t'(req_op[2*t +: 2]), ilat: req_lat[LAT_W*t +: LAT_W]};
                end else if (finishing && owner == TIDW'(t)) begin
                    pend[t] <= 1'b0;
                end
            end
        end
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        lldiv_grp_queue #(.DEPTH(GRP_SZ)) u_q (
            .clk      (clk),
            .rst      (rst),
            .push     (acc[g*GRP_SZ +: GRP_SZ]),
            .pop      (gnt && gsel == 1'(g)),
            .head     (head[g]),
            .nonempty (ne[g])
        );
    end

    lldiv_grp_arb u_arb (
        .clk  (clk),
        .rst  (rst),
        .idle (!busy),
        .ne   (ne),
        .gnt  (gnt),
        .gsel (gsel)
    );

    assign gnt_tid = {gsel, head[gsel]};
    assign gnt_cyc = occ_cycles(rec[gnt_tid].op, rec[gnt_tid].ilat);

    lldiv_occ_timer #(.NTHR(NTHR)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .start     (gnt),
        .start_tid (gnt_tid),
        .start_cyc (gnt_cyc),
        .busy      (busy),
        .finishing (finishing),
        .owner     (owner),
        .done      (done)
    );

    // R8: only an outstanding request can be granted or completed.
    p_grant_pending_r8: assert property (@(posedge clk) disable iff (rst)
        gnt |-> pend[gnt_tid]);
    p_finish_pending_r8: assert property (@(posedge clk) disable iff (rst)
        finishing |-> pend[owner]);

    // R1: the arbiter never grants while the timer is occupied.
    p_grant_idle_r1: assert property (@(posedge clk) disable iff (rst)
        gnt |-> !busy);

endmodule

// File: tb/lldiv_sched_tb.sv
module lldiv_sched_tb;

    localparam int NTHR = 8;
    localparam int LW   = 6;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NTHR-1:0]     req_valid = '0;
    logic [2*NTHR-1:0]   req_op = '0;
    logic [LW*NTHR-1:0]  req_lat = '0;
    logic [NTHR-1:0]     done;
    logic                busy;

    lldiv_sched u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_lat(req_lat), .done(done), .busy(busy)
    );

    always #5 clk = ~clk;

    typedef struct packed { int tid; int op; int lat; int dur; } vec_t;
    localparam vec_t TBL [12] = '{
        '{0, 0,  0, 19}, '{5, 0, 40, 19}, '{3, 1,  0, 33}, '{6, 1, 12, 33},
        '{1, 2, 20, 20}, '{7, 2,  5, 12}, '{2, 2, 63, 41}, '{4, 2, 12, 12},
        '{0, 2, 41, 41}, '{5, 3, 30, 30}, '{3, 2, 11, 12}, '{6, 2, 42, 41}
    };

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int log_n = 0;
    int ovl = 0;
    int log_tid [64];

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Completion monitor: records every strobe, flags overlap with busy.
    always @(negedge clk) begin
        cyc++;
        if (!rst && done != '0) begin
            if ($countones(done) > 1 || busy) ovl++;
            for (int t = 0; t < NTHR; t++)
                if (done[t] && log_n < 64) begin
                    log_tid[log_n] = t;
                    log_n++;
                end
        end
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input int t, input int op, input int lat);
        req_valid[t]        = 1'b1;
        req_op[2*t +: 2]    = 2'(op);
        req_lat[LW*t +: LW] = LW'(lat);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_log(input int n);
        for (int i = 0; i < 3000 && log_n < n; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_one(input int t, input int op, input int lat, input int exp, input string tag);
        int dur;
        dur = 0;
        log_n = 0;
        drive(t, op, lat);
        @(negedge clk);
        req_valid = '0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (busy) dur++;
            if (done != '0) break;
        end
        @(negedge clk);
        chk(dur == exp, tag, dur, exp);
        chk(log_n == 1 && log_tid[0] == t, {tag, " owner"}, log_tid[0], t);
    endtask

    task automatic chk_seq(input int exp [8], input int n, input string tag);
        chk(log_n == n, {tag, " count"}, log_n, n);
        for (int i = 0; i < n; i++)
            chk(log_tid[i] == exp[i], tag, log_tid[i], exp[i]);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        // R10: reset state
        chk(busy == 1'b0, "R10 busy after reset", int'(busy), 0);
        chk(done == '0, "R10 done after reset", int'(done), 0);

        // R2 R3 R4: occupancy per operation class, walked from the table
        for (int k = 0; k < 12; k++) begin
            run_one(TBL[k].tid, TBL[k].op, TBL[k].lat, TBL[k].dur,
                    TBL[k].op == 0 ? "R2 single occupancy" :
                    TBL[k].op == 1 ? "R3 double occupancy" : "R4 integer occupancy");
        end

        // R5: arrival order inside group A
        log_n = 0;
        drive(2, 0, 0); @(negedge clk); req_valid = '0;
        drive(1, 0, 0); @(negedge clk); req_valid = '0;
        drive(3, 0, 0); @(negedge clk); req_valid = '0;
        drive(0, 0, 0); @(negedge clk); req_valid = '0;
        wait_log(4);
        chk_seq('{2, 1, 3, 0, 0, 0, 0, 0}, 4, "R5 fifo order");

        // R5: same-cycle arrivals in group B, lower index first
        log_n = 0;
        drive(7, 0, 0); @(negedge clk); req_valid = '0;
        drive(6, 0, 0); drive(5, 0, 0); @(negedge clk); req_valid = '0;
        drive(4, 0, 0); @(negedge clk); req_valid = '0;
        wait_log(4);
        chk_seq('{7, 5, 6, 4, 0, 0, 0, 0}, 4, "R5 tie order");

        // R6: both groups loaded, last grant was group B
        log_n = 0;
        drive(0, 0, 0); drive(1, 0, 0); drive(2, 0, 0);
        drive(4, 0, 0); drive(5, 0, 0); drive(6, 0, 0);
        @(negedge clk); req_valid = '0;
        wait_log(6);
        chk_seq('{0, 4, 1, 5, 2, 6, 0, 0}, 6, "R6 alternation");

        // R7: group B runs dry after one grant
        log_n = 0;
        drive(0, 0, 0); drive(1, 0, 0); drive(2, 0, 0); drive(3, 0, 0); drive(5, 0, 0);
        @(negedge clk); req_valid = '0;
        wait_log(5);
        chk_seq('{0, 5, 1, 2, 3, 0, 0, 0}, 5, "R7 yield");

        // R8: repeat strobe while outstanding is ignored
        begin
            int dur;
            dur = 0;
            log_n = 0;
            drive(3, 1, 0); @(negedge clk); req_valid = '0;
            for (int i = 0; i < 60; i++) begin
                if (i == 5) drive(3, 0, 0);
                if (i == 6) req_valid = '0;
                @(negedge clk);
                if (busy) dur++;
            end
            tick(40);
            chk(dur == 33, "R8 occupancy unchanged", dur, 33);
            chk(log_n == 1, "R8 single completion", log_n, 1);
        end

        // R9: reissue in own completion cycle while a group peer waits
        log_n = 0;
        drive(0, 0, 0); @(negedge clk); req_valid = '0;
        drive(2, 0, 0); @(negedge clk); req_valid = '0;
        for (int i = 0; i < 200; i++) begin
            if (done[0]) break;
            @(negedge clk);
        end
        chk(done[0] == 1'b1, "R9 completion seen", int'(done[0]), 1);
        chk(busy == 1'b0, "R9 busy low in completion cycle", int'(busy), 0);
        drive(0, 0, 0);
        @(negedge clk); req_valid = '0;
        chk(busy == 1'b1, "R9 next grant follows", int'(busy), 1);
        chk(done == '0, "R9 strobe one cycle", int'(done), 0);
        wait_log(3);
        chk_seq('{0, 2, 0, 0, 0, 0, 0, 0}, 3, "R9 order");

        // R1: no overlapping completions and no strobe while busy
        chk(ovl == 0, "R1 exclusive occupancy", ovl, 0);

        // R10: reset mid-operation drops everything
        drive(1, 1, 0); @(negedge clk); req_valid = '0;
        tick(5);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        log_n = 0;
        chk(busy == 1'b0, "R10 busy after mid reset", int'(busy), 0);
        tick(40);
        chk(log_n == 0, "R10 no stale completion", log_n, 0);
        run_one(1, 1, 0, 33, "R10 thread free after reset");

        summary();
    end

endmodule